// File: doc/BRIEF.md
# Cache Test-Register Line Loader

This block gives software a back door into the storage of a 16 KB, four-way set-associative cache with 16-byte lines. Three 32-bit registers are reached over a simple write-only register bus. A data register fills one dword of a four-dword staging buffer. A tag register holds an address tag and a valid flag. A control register does one of two jobs, chosen by its low two bits. With command 00 it points the next data write at one buffer dword. With command 01 it copies the whole buffer, the tag and the valid flag into the line named by its index and way fields.

Preloading lines this way lets boot code or a display driver pin known data at known addresses before external memory works. A bulk invalidate input drops every line except those guarded by a lock window. The lock window covers a set of ways, given as a mask, and a run of low indices, given as a count. A combinational read port exposes any line's tag, valid flag and data. This port lets the contents be inspected.

Top module: `ctr_line_loader`

## Requirements
- R1: After reset every line of every way reads back as not valid, the dword pointer is 0 and the staged tag and valid flag are 0.
- R2: Register select `wr_sel_i` is encoded 0 = data, 1 = tag, 2 = control, 3 = spare. A data write stores `wr_data_i` into the buffer dword selected by the pointer. The pointer is loaded from control bits [3:2] (byte offset 0x0, 0x4, 0x8, 0xC gives dword 0..3) by a control write whose bits [1:0] are 00.
- R3: A tag write keeps bits [31:12] as the line tag and bit 10 as the valid flag. Every other bit of that write has no effect on what a later commit stores.
- R4: A control write with bits [1:0] = 01 commits the buffer, tag and valid flag into the line at index bits [11:4] of way bits [3:2]. The write is captured at the clock edge that samples it, and the line changes at the following edge, not before.
- R5: A control write with command 00 never changes any line. A control write with command 10 or 11 changes neither any line nor the dword pointer.
- R6: Commits on two consecutive cycles to different lines both land with the correct contents.
- R7: A commit leaves the buffer, tag and valid flag unchanged, so they can be committed again to another line.
- R8: While `inv_i` is high at a clock edge, every valid flag is cleared except on lines whose way bit is set in `lock_way_i` and whose index is below `lock_lines_i`. Tags and data are not changed.
- R9: When a commit lands at the same edge as an invalidate, the committed line takes the commit's valid flag.
- R10: A register write with `wr_sel_i` = 3 has no effect on the buffer, the tag, the pointer or any line.
- R11: The read port returns, in the same cycle, the tag, the valid flag and the four dwords of the line at `rd_idx_i` / `rd_way_i`, with dword 0 in bits [31:0] and dword 3 in bits [127:96].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 data, 1 tag, 2 control, 3 spare |
| wr_data_i | input | 32 | Register write value |
| inv_i | input | 1 | Bulk invalidate request |
| lock_way_i | input | 4 | Ways covered by the lock window |
| lock_lines_i | input | 9 | Number of low indices covered by the lock window (0..256) |
| rd_idx_i | input | 8 | Read port line index |
| rd_way_i | input | 2 | Read port way |
| rd_tag_o | output | 20 | Stored tag of the addressed line |
| rd_valid_o | output | 1 | Stored valid flag of the addressed line |
| rd_line_o | output | 128 | Stored data of the addressed line |

## Verification
The embedded properties take for granted that all inputs are driven to known values once reset is released. They also assume that `lock_way_i` and `lock_lines_i` are steady across an invalidate edge. In addition, the retention checks on the buffer and pointer require the write strobe to be low whenever no register access is meant. The stimulus changes every input only on the falling clock edge and holds the lock inputs constant around each invalidate pulse. It drops `wr_en_i` between accesses, except in the deliberate back-to-back commit case and the commit-plus-invalidate case.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // register select on the write bus
   typedef enum logic [1:0] {
      SEL_DATA  = 2'd0,
      SEL_TAG   = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_SPARE = 2'd3
   } ctr_sel_e;

   // command field held in the low bits of a control write
   typedef enum logic [1:0] {
      CMD_POINT  = 2'd0,
      CMD_COMMIT = 2'd1,
      CMD_RSV_A  = 2'd2,
      CMD_RSV_B  = 2'd3
   } ctr_cmd_e;

endpackage

// File: rtl/ctr_reg_port.sv
module ctr_reg_port
   import ctr_pkg::*;
#(
   parameter int DW        = 32,
   parameter int WORDS     = 4,
   parameter int IDX_W     = 8,
   parameter int WAY_W     = 2,
   parameter int VALID_BIT = 10,
   localparam int LANE_W   = $clog2(DW / 8),
   localparam int WSEL_W   = $clog2(WORDS),
   localparam int BOFS_W   = LANE_W + WSEL_W,
   localparam int TAG_LSB  = BOFS_W + IDX_W,
   localparam int TAG_W    = DW - TAG_LSB,
   localparam int LINE_W   = WORDS * DW
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic              cmt_en_o,
   output logic [IDX_W-1:0]  cmt_idx_o,
   output logic [WAY_W-1:0]  cmt_way_o,
   output logic [TAG_W-1:0]  cmt_tag_o,
   output logic              cmt_valid_o,
   output logic [LINE_W-1:0] cmt_line_o
);

   logic [WORDS-1:0][DW-1:0] fill_q;
   logic [WSEL_W-1:0]        ptr_q;
   logic [TAG_W-1:0]         tag_q;
   logic                     vflag_q;

   logic     do_data, do_tag, do_ctrl;
   ctr_cmd_e cmd;

   assign cmd     = ctr_cmd_e'(wr_data_i[1:0]);
   assign do_data = wr_en_i && (ctr_sel_e'(wr_sel_i) == SEL_DATA);
   assign do_tag  = wr_en_i && (ctr_sel_e'(wr_sel_i) == SEL_TAG);
   assign do_ctrl = wr_en_i && (ctr_sel_e'(wr_sel_i) == SEL_CTRL);

   // dword pointer: moved only by a pointer command
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (do_ctrl && cmd == CMD_POINT) begin
         ptr_q <= wr_data_i[BOFS_W-1:LANE_W];
      end
   end

   // staging buffer
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fill_q <= '0;
      end else if (do_data) begin
         fill_q[ptr_q] <= wr_data_i;
      end
   end

   // tag and valid flag
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tag_q   <= '0;
         vflag_q <= 1'b0;
      end else if (do_tag) begin
         tag_q   <= wr_data_i[DW-1:TAG_LSB];
         vflag_q <= wr_data_i[VALID_BIT];
      end
   end

   // commit staging: snapshot taken at the control write, applied one edge later
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmt_en_o <= 1'b0;
      end else begin
         cmt_en_o <= do_ctrl && (cmd == CMD_COMMIT);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmt_idx_o   <= '0;
         cmt_way_o   <= '0;
         cmt_tag_o   <= '0;
         cmt_valid_o <= 1'b0;
         cmt_line_o  <= '0;
      end else if (do_ctrl && cmd == CMD_COMMIT) begin
         cmt_idx_o   <= wr_data_i[TAG_LSB-1:BOFS_W];
         cmt_way_o   <= wr_data_i[LANE_W+WAY_W-1:LANE_W];
         cmt_tag_o   <= tag_q;
         cmt_valid_o <= vflag_q;
         cmt_line_o  <= fill_q;
      end
   end

   // R4
   commit_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'd2 && wr_data_i[1:0] == 2'b01) |=> cmt_en_o);

   // R5
   ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == 2'd2 && wr_data_i[1:0] == 2'b00) |=> $stable(ptr_q));

   // R2
   fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == 2'd0) |=> $stable(fill_q));

   // R7
   tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == 2'd1) |=> ($stable(tag_q) && $stable(vflag_q)));

endmodule

// File: rtl/ctr_way_bank.sv
module ctr_way_bank #(
   parameter int  SETS    = 256,
   parameter int  TAG_W   = 20,
   parameter int  LINE_W  = 128,
   parameter bit  LOCK_EN = 1'b1,
   localparam int IDX_W   = $clog2(SETS),
   localparam int LCNT_W  = IDX_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [TAG_W-1:0]  wr_tag_i,
   input  logic              wr_valid_i,
   input  logic [LINE_W-1:0] wr_line_i,
   input  logic              inv_i,
   input  logic              lock_way_i,
   input  logic [LCNT_W-1:0] lock_lines_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [TAG_W-1:0]  rd_tag_o,
   output logic              rd_valid_o,
   output logic [LINE_W-1:0] rd_line_o
);

   logic [LINE_W-1:0] data_q [SETS];
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   valid_n;
   logic [SETS-1:0]   keep_mask;

   // lock window: variant chosen by parameter
   if (LOCK_EN) begin : g_lock
      for (genvar i = 0; i < SETS; i++) begin : g_keep
         assign keep_mask[i] = lock_way_i && (LCNT_W'(i) < lock_lines_i);
      end
   end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = lock_way_i ^ (^lock_lines_i);
      assign keep_mask   = '0;
   end

   // valid flags: invalidate first, then a landing commit overrides its line
   always_comb begin
      valid_n = valid_q;
      if (inv_i) begin
         valid_n = valid_q & keep_mask;
      end
      if (wr_en_i) begin
         valid_n[wr_idx_i] = wr_valid_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
      end else begin
         valid_q <= valid_n;
      end
   end

   // payload storage carries no reset
   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         data_q[wr_idx_i] <= wr_line_i;
         tag_q[wr_idx_i]  <= wr_tag_i;
      end
   end

   assign rd_tag_o   = tag_q[rd_idx_i];
   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_line_o  = data_q[rd_idx_i];

   // R4
   commit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)));

   // R4
   commit_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (tag_q[$past(wr_idx_i)] == $past(wr_tag_i)));

   // R8
   inv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_i && !wr_en_i) |=> ((valid_q & ~$past(keep_mask)) == '0));

   // R8
   inv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_i && !wr_en_i) |=> ((valid_q & $past(keep_mask)) == $past(valid_q & keep_mask)));

   // R5
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inv_i && !wr_en_i) |=> $stable(valid_q));

endmodule

// File: rtl/ctr_line_loader.sv
module ctr_line_loader
   import ctr_pkg::*;
#(
   parameter int  WAYS      = 4,
   parameter int  SETS      = 256,
   parameter int  WORDS     = 4,
   parameter int  DW        = 32,
   parameter int  VALID_BIT = 10,
   parameter bit  LOCK_EN   = 1'b1,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int IDX_W     = $clog2(SETS),
   localparam int LANE_W    = $clog2(DW / 8),
   localparam int BOFS_W    = LANE_W + $clog2(WORDS),
   localparam int TAG_LSB   = BOFS_W + IDX_W,
   localparam int TAG_W     = DW - TAG_LSB,
   localparam int LINE_W    = WORDS * DW
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic              inv_i,
   input  logic [WAYS-1:0]   lock_way_i,
   input  logic [IDX_W:0]    lock_lines_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  logic [WAY_W-1:0]  rd_way_i,
   output logic [TAG_W-1:0]  rd_tag_o,
   output logic              rd_valid_o,
   output logic [LINE_W-1:0] rd_line_o
);

   // elaboration-time parameter checks
   if ((1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (LANE_W < 2) begin : g_bad_dw
      $error("DW must be at least 32 to hold a command field");
   end
   if (LANE_W + WAY_W > BOFS_W) begin : g_bad_way_field
      $error("way field does not fit below the line index");
   end
   if (VALID_BIT >= TAG_LSB || VALID_BIT < 0) begin : g_bad_vbit
      $error("valid bit must sit below the tag field");
   end

   logic              cmt_en;
   logic [IDX_W-1:0]  cmt_idx;
   logic [WAY_W-1:0]  cmt_way;
   logic [TAG_W-1:0]  cmt_tag;
   logic              cmt_valid;
   logic [LINE_W-1:0] cmt_line;

   ctr_reg_port #(
      .DW        (DW),
      .WORDS     (WORDS),
      .IDX_W     (IDX_W),
      .WAY_W     (WAY_W),
      .VALID_BIT (VALID_BIT)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .cmt_en_o    (cmt_en),
      .cmt_idx_o   (cmt_idx),
      .cmt_way_o   (cmt_way),
      .cmt_tag_o   (cmt_tag),
      .cmt_valid_o (cmt_valid),
      .cmt_line_o  (cmt_line)
   );

   logic [TAG_W-1:0]  bank_tag   [WAYS];
   logic [WAYS-1:0]   bank_valid;
   logic [LINE_W-1:0] bank_line  [WAYS];
   logic [WAYS-1:0]   bank_wr;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign bank_wr[g] = cmt_en && (cmt_way == WAY_W'(g));

      ctr_way_bank #(
         .SETS    (SETS),
         .TAG_W   (TAG_W),
         .LINE_W  (LINE_W),
         .LOCK_EN (LOCK_EN)
      ) u_bank (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .wr_en_i      (bank_wr[g]),
         .wr_idx_i     (cmt_idx),
         .wr_tag_i     (cmt_tag),
         .wr_valid_i   (cmt_valid),
         .wr_line_i    (cmt_line),
         .inv_i        (inv_i),
         .lock_way_i   (lock_way_i[g]),
         .lock_lines_i (lock_lines_i),
         .rd_idx_i     (rd_idx_i),
         .rd_tag_o     (bank_tag[g]),
         .rd_valid_o   (bank_valid[g]),
         .rd_line_o    (bank_line[g])
      );
   end

   assign rd_tag_o   = bank_tag[rd_way_i];
   assign rd_valid_o = bank_valid[rd_way_i];
   assign rd_line_o  = bank_line[rd_way_i];

   // R6
   one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_wr));

   // R4
   commit_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_en |-> $countones(bank_wr) == 1);

endmodule

// File: tb/ctr_line_loader_tb.sv
module ctr_line_loader_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [31:0]  wr_data = '0;
   logic         inv = 1'b0;
   logic [3:0]   lock_way = '0;
   logic [8:0]   lock_lines = '0;
   logic [7:0]   rd_idx = '0;
   logic [1:0]   rd_way = '0;
   logic [19:0]  rd_tag;
   logic         rd_valid;
   logic [127:0] rd_line;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ctr_line_loader dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .wr_en_i      (wr_en),
      .wr_sel_i     (wr_sel),
      .wr_data_i    (wr_data),
      .inv_i        (inv),
      .lock_way_i   (lock_way),
      .lock_lines_i (lock_lines),
      .rd_idx_i     (rd_idx),
      .rd_way_i     (rd_way),
      .rd_tag_o     (rd_tag),
      .rd_valid_o   (rd_valid),
      .rd_line_o    (rd_line)
   );

   typedef struct packed {
      logic [7:0]  idx;
      logic [1:0]  way;
      logic [31:0] seed;
      logic [19:0] tag;
      logic        v;
   } vec_t;

   localparam vec_t TABLE [8] = '{
      {8'h00, 2'd0, 32'h1000_0001, 20'h4_0000, 1'b1},
      {8'hFF, 2'd3, 32'hA5A5_0F0F, 20'hF_FFFF, 1'b1},
      {8'h03, 2'd1, 32'h3333_0003, 20'h1_2345, 1'b1},
      {8'hC8, 2'd1, 32'hDEAD_00C8, 20'h8_00C8, 1'b1},
      {8'h05, 2'd0, 32'h0505_0505, 20'h0_0505, 1'b1},
      {8'h80, 2'd2, 32'h8080_1234, 20'hC_0080, 1'b0},
      {8'h0F, 2'd1, 32'h0F0F_7777, 20'h0_F00F, 1'b1},
      {8'h10, 2'd1, 32'h1010_9999, 20'h1_0010, 1'b1}
   };

   function automatic logic [31:0] word_of(input logic [31:0] seed, input int k);
      return seed + 32'h1111_1111 * k;
   endfunction

   function automatic logic [127:0] line_of(input logic [31:0] seed);
      return {word_of(seed, 3), word_of(seed, 2), word_of(seed, 1), word_of(seed, 0)};
   endfunction

   // tag write value: tag in [31:12], valid in [10], junk in [11] and [9:0] (R3)
   function automatic logic [31:0] tag_word(input logic [19:0] t, input logic v);
      return {t, 1'b1, v, 10'h2A5};
   endfunction

   function automatic logic [31:0] commit_word(input logic [7:0] idx, input logic [1:0] way);
      return {20'h0, idx, way, 2'b01};
   endfunction

   function automatic logic [31:0] point_word(input logic [1:0] dw);
      return {28'h0, dw, 2'b00};
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic load_words(input logic [31:0] seed);
      for (int k = 0; k < 4; k++) begin
         reg_wr(2'd2, point_word(2'(k)));
         reg_wr(2'd0, word_of(seed, k));
      end
   endtask

   task automatic look(input logic [7:0] idx, input logic [1:0] way);
      rd_idx = idx;
      rd_way = way;
      #1;
   endtask

   task automatic check_line(input string req, input logic [7:0] idx, input logic [1:0] way,
                             input logic [19:0] t, input logic v, input logic [127:0] ln);
      look(idx, way);
      check(req, 128'(rd_tag), 128'(t));
      check(req, 128'(rd_valid), 128'(v));
      check(req, rd_line, ln);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      logic [127:0] exp_ln;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: all lines invalid after reset
      look(8'h00, 2'd0); check("R1 valid (0,0)", 128'(rd_valid), 128'd0);
      look(8'hFF, 2'd3); check("R1 valid (255,3)", 128'(rd_valid), 128'd0);
      look(8'h80, 2'd2); check("R1 valid (128,2)", 128'(rd_valid), 128'd0);
      // R1: zero tag/valid and pointer 0 staged; data write lands in dword 0
      reg_wr(2'd0, 32'h0BAD_F00D);
      reg_wr(2'd2, commit_word(8'h77, 2'd2));
      @(negedge clk);
      check_line("R1 reset tag/pointer", 8'h77, 2'd2, 20'h0, 1'b0, {96'h0, 32'h0BAD_F00D});

      // R2 R3 R4 R11: table of vectors
      foreach (TABLE[e]) begin
         load_words(TABLE[e].seed);
         reg_wr(2'd1, tag_word(TABLE[e].tag, TABLE[e].v));
         reg_wr(2'd2, commit_word(TABLE[e].idx, TABLE[e].way));
         @(negedge clk);
         check_line("R2 R3 R4 R11 table", TABLE[e].idx, TABLE[e].way,
                    TABLE[e].tag, TABLE[e].v, line_of(TABLE[e].seed));
      end

      // R4: line changes one edge after the capture edge, not at it
      load_words(32'h2222_0022);
      reg_wr(2'd1, tag_word(20'h2_2222, 1'b1));
      reg_wr(2'd2, commit_word(8'h22, 2'd3));
      look(8'h22, 2'd3); check("R4 not yet landed", 128'(rd_valid), 128'd0);
      @(negedge clk);
      check_line("R4 landed", 8'h22, 2'd3, 20'h2_2222, 1'b1, line_of(32'h2222_0022));

      // R5: pointer commands leave the array alone
      reg_wr(2'd2, point_word(2'd1));
      @(negedge clk);
      check_line("R5 cmd00 no change", 8'h00, 2'd0, TABLE[0].tag, 1'b1, line_of(TABLE[0].seed));
      look(8'h00, 2'd1); check("R5 cmd00 no new line", 128'(rd_valid), 128'd0);
      // R5: reserved command changes neither pointer nor lines
      load_words(32'h5555_0000);
      reg_wr(2'd2, point_word(2'd1));
      reg_wr(2'd2, {20'h0, 8'h33, 2'b11, 2'b10});
      reg_wr(2'd0, 32'hCAFE_0001);
      @(negedge clk);
      look(8'h33, 2'd3); check("R5 cmd10 no line", 128'(rd_valid), 128'd0);
      reg_wr(2'd1, tag_word(20'h3_3333, 1'b1));
      reg_wr(2'd2, commit_word(8'h33, 2'd2));
      @(negedge clk);
      exp_ln = line_of(32'h5555_0000);
      exp_ln[63:32] = 32'hCAFE_0001;
      check_line("R5 cmd10 pointer kept", 8'h33, 2'd2, 20'h3_3333, 1'b1, exp_ln);

      // R10: spare select ignored
      reg_wr(2'd3, 32'hFFFF_FFFF);
      reg_wr(2'd2, commit_word(8'h34, 2'd2));
      @(negedge clk);
      check_line("R10 spare ignored", 8'h34, 2'd2, 20'h3_3333, 1'b1, exp_ln);

      // R6 R7: back-to-back commits reuse the retained buffer and tag
      load_words(32'h6060_0006);
      reg_wr(2'd1, tag_word(20'h6_0606, 1'b1));
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = commit_word(8'h50, 2'd0);
      @(negedge clk);
      wr_data = commit_word(8'h51, 2'd3);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check_line("R6 first", 8'h50, 2'd0, 20'h6_0606, 1'b1, line_of(32'h6060_0006));
      check_line("R6 R7 second", 8'h51, 2'd3, 20'h6_0606, 1'b1, line_of(32'h6060_0006));

      // R8: invalidate with lock window way 1, indices 0..15
      lock_way = 4'b0010;
      lock_lines = 9'd16;
      @(negedge clk);
      inv = 1'b1;
      @(negedge clk);
      inv = 1'b0;
      look(8'h03, 2'd1); check("R8 locked idx3", 128'(rd_valid), 128'd1);
      look(8'h0F, 2'd1); check("R8 locked idx15", 128'(rd_valid), 128'd1);
      look(8'h10, 2'd1); check("R8 idx16 cleared", 128'(rd_valid), 128'd0);
      look(8'h00, 2'd0); check("R8 way0 cleared", 128'(rd_valid), 128'd0);
      look(8'hFF, 2'd3); check("R8 way3 cleared", 128'(rd_valid), 128'd0);
      check_line("R8 payload kept", 8'hC8, 2'd1, TABLE[3].tag, 1'b0, line_of(TABLE[3].seed));

      // R9: commit landing on the invalidate edge keeps its valid flag
      lock_way = 4'b0000;
      lock_lines = 9'd0;
      load_words(32'h9090_0009);
      reg_wr(2'd1, tag_word(20'h9_0909, 1'b1));
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = commit_word(8'h60, 2'd2);
      @(negedge clk);
      wr_en = 1'b0;
      inv = 1'b1;
      @(negedge clk);
      inv = 1'b0;
      check_line("R9 commit wins", 8'h60, 2'd2, 20'h9_0909, 1'b1, line_of(32'h9090_0009));
      look(8'h03, 2'd1); check("R9 others cleared", 128'(rd_valid), 128'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule